// File: doc/BRIEF.md
# Standby and Clock-Gating Power Controller

This block manages power for a small processor subsystem. It watches halt and sleep requests from the CPU, an external bus-request line and the wake-up interrupt lines. From these it holds one of several power states and drives a separate enable for each power domain: the CPU clock, the bus controller and bus clock, DMA, the high-speed oscillator, the prescaler-fed peripherals, and memory refresh. The oscillators are modelled as enable flags, and the system clock is modelled as a tick enable.

A halt request gives one of two standby depths, chosen by a configuration bit. A sleep request always gives the deepest state. A bus request, when the bus-release bit is set, parks the CPU in a basic halt that interrupts cannot end. A configuration register sets the halt depth, the bus-release enable, the low-speed oscillator enable, the clock source and the fast-clock divider. Port interrupts normally follow their own edge or level setting. They are forced to level sensitivity for as long as any standby state is held.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: After reset the state is run (`mode_o`=0), every domain enable is 1, the low-speed oscillator is on, the fast source is selected with ratio 1, halt depth is basic and bus release is disabled.
- R2: A cycle with `cfg_we_i`=1 loads `cfg_wdata_i` as bit0 halt depth (1=deep), bit1 bus-release enable, bit2 low-speed oscillator on, bit3 slow-clock select, bits5:4 divider select. The new values take effect from the next cycle. `slow_osc_en_o` follows bit2 in every state.
- R3: A halt request with halt depth 0 enters basic halt (`mode_o`=1). In basic halt the CPU clock and DMA are off, and the bus clock, peripherals, fast oscillator and refresh stay on.
- R4: A halt request with halt depth 1 enters deep halt (`mode_o`=3). In deep halt the CPU, bus clock, DMA and refresh are off, and the peripherals and fast oscillator stay on.
- R5: A sleep request enters sleep (`mode_o`=4) and takes priority over a halt request in the same cycle. In sleep every domain enable, including the fast oscillator and the peripherals, is off.
- R6: From run, `busreq_i` with bus release enabled enters bus halt (`mode_o`=2). This has the highest priority, and the domain enables match basic halt. Interrupts do not end bus halt. The state returns to run at the first clock edge that sees `busreq_i` low. With bus release disabled, `busreq_i` has no effect.
- R7: In basic or deep halt, any `irq_i` bit or any active `port_irq_o` bit returns the state to run at the next edge.
- R8: A wake-up interrupt in sleep enters the settle state (`mode_o`=5). In the settle state only the fast oscillator is enabled. After exactly SETTLE_CYC cycles the state returns to run.
- R9: While the slow clock is selected, `refresh_en_o` and `fast_osc_en_o` are 0 in run, and `sysclk_slow_o` is 1.
- R10: With the fast source selected and running, `sysclk_tick_o` pulses once every 1, 2, 4 or 8 cycles for divider select 0, 1, 2 or 3.
- R11: With the slow clock selected, `sysclk_tick_o` equals `slow_tick_i` while the low-speed oscillator is on, and is 0 while it is off.
- R12: In run, a port configured for edge (`port_edge_i` bit 1) raises `port_irq_o` only in the first cycle after its pin rises. In any standby state, every port reports its pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | 1 | CPU halt request pulse |
| sleep_req_i | input | 1 | CPU sleep request pulse |
| busreq_i | input | 1 | External bus-master request |
| irq_i | input | N_IRQ | Enabled interrupt requests (level) |
| port_pin_i | input | N_PORT | Port interrupt pin levels |
| port_edge_i | input | N_PORT | Per-port trigger type, 1 = rising edge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Configuration write data |
| slow_tick_i | input | 1 | Low-speed oscillator tick |
| port_irq_o | output | N_PORT | Qualified port interrupts |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| bus_clk_en_o | output | 1 | Bus controller and bus clock enable |
| dma_en_o | output | 1 | DMA enable |
| fast_osc_en_o | output | 1 | High-speed oscillator enable |
| slow_osc_en_o | output | 1 | Low-speed oscillator and clock-timer enable |
| periph_clk_en_o | output | 1 | Prescaler and peripheral clock enable |
| refresh_en_o | output | 1 | Memory refresh enable |
| sysclk_slow_o | output | 1 | System clock runs from slow source |
| sysclk_tick_o | output | 1 | System clock tick enable |
| mode_o | output | 3 | Current power state |

## Verification
A wrong state register shows up at the domain enables in the very next cycle, because every enable is decoded straight from the registered state. For example, a state that stays in a halt after a wake-up interrupt leaves `cpu_clk_en_o` low one cycle too long. A settle counter loaded with the wrong value shows only at the end of the settle state, as run resuming early or late by that many cycles. A bad divider count shows only as a wrong tick count over a window of several periods. For that reason the bench counts ticks over 16 cycles instead of checking single pulses.

// File: rtl/stby_pkg.sv
package stby_pkg;
  localparam int DIV_W = 2;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_HALT      = 3'd1,
    ST_HALT_BUS  = 3'd2,
    ST_HALT_DEEP = 3'd3,
    ST_SLEEP     = 3'd4,
    ST_WAKE      = 3'd5
  } stby_state_e;

  typedef struct packed {
    logic [DIV_W-1:0] div_sel;
    logic             slow_sel;
    logic             slow_osc_on;
    logic             bus_rel_en;
    logic             halt_deep;
  } stby_cfg_t;

  localparam int CFG_W = $bits(stby_cfg_t);

  localparam stby_cfg_t CFG_RST = '{
    div_sel:     '0,
    slow_sel:    1'b0,
    slow_osc_on: 1'b1,
    bus_rel_en:  1'b0,
    halt_deep:   1'b0
  };
endpackage

// File: rtl/stby_cfg_regs.sv
module stby_cfg_regs
  import stby_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output stby_cfg_t        cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= CFG_RST;
    else if (we_i) cfg_o <= stby_cfg_t'(wdata_i);
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        halt_req_i,
  input  logic        sleep_req_i,
  input  logic        busreq_i,
  input  logic        bus_rel_en_i,
  input  logic        halt_deep_i,
  input  logic        wake_i,
  output stby_state_e state_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  stby_state_e     state_d;
  logic [SW-1:0]   cnt_q, cnt_d;

  always_comb begin
    state_d = state_o;
    cnt_d   = cnt_q;
    unique case (state_o)
      ST_RUN: begin
        if (busreq_i && bus_rel_en_i) state_d = ST_HALT_BUS;
        else if (sleep_req_i)         state_d = ST_SLEEP;
        else if (halt_req_i)          state_d = halt_deep_i ? ST_HALT_DEEP : ST_HALT;
      end
      ST_HALT_BUS: if (!busreq_i) state_d = ST_RUN;
      ST_HALT, ST_HALT_DEEP: if (wake_i) state_d = ST_RUN;
      ST_SLEEP: if (wake_i) begin
        state_d = ST_WAKE;
        cnt_d   = SW'(SETTLE_CYC - 1);
      end
      ST_WAKE: begin
        if (cnt_q == '0) state_d = ST_RUN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_o <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/stby_port_irq.sv
module stby_port_irq #(
  parameter int N_PORT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PORT-1:0] pin_i,
  input  logic [N_PORT-1:0] edge_cfg_i,
  input  logic              standby_i,
  output logic [N_PORT-1:0] irq_o
);
  logic [N_PORT-1:0] pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    // standby forces level sensitivity
    assign irq_o[g] = (standby_i || !edge_cfg_i[g]) ? pin_i[g] : (pin_i[g] & ~pin_q[g]);
  end
endmodule

// File: rtl/stby_clk_div.sv
module stby_clk_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_run_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             slow_sel_i,
  input  logic             slow_run_i,
  input  logic             slow_tick_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] reload;
  logic             active;

  assign ratio  = (CNT_W + 1)'(1) << div_sel_i;
  assign reload = CNT_W'(ratio - 1'b1);
  assign active = fast_run_i && !slow_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!active)      cnt_q <= '0;
    else if (cnt_q == '0)  cnt_q <= reload;
    else                   cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = slow_sel_i ? (slow_run_i && slow_tick_i) : (active && cnt_q == '0);
endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
  import stby_pkg::*;
#(
  parameter int N_IRQ      = 2,
  parameter int N_PORT     = 2,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_req_i,
  input  logic              sleep_req_i,
  input  logic              busreq_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_PORT-1:0] port_pin_i,
  input  logic [N_PORT-1:0] port_edge_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              slow_tick_i,
  output logic [N_PORT-1:0] port_irq_o,
  output logic              cpu_clk_en_o,
  output logic              bus_clk_en_o,
  output logic              dma_en_o,
  output logic              fast_osc_en_o,
  output logic              slow_osc_en_o,
  output logic              periph_clk_en_o,
  output logic              refresh_en_o,
  output logic              sysclk_slow_o,
  output logic              sysclk_tick_o,
  output logic [2:0]        mode_o
);
  stby_cfg_t   cfg;
  stby_state_e state;
  logic        wake;

  stby_cfg_regs i_cfg (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  stby_port_irq #(.N_PORT(N_PORT)) i_port (
    .clk_i, .rst_ni,
    .pin_i      (port_pin_i),
    .edge_cfg_i (port_edge_i),
    .standby_i  (state != ST_RUN),
    .irq_o      (port_irq_o)
  );

  assign wake = (|irq_i) || (|port_irq_o);

  stby_fsm #(.SETTLE_CYC(SETTLE_CYC)) i_fsm (
    .clk_i, .rst_ni,
    .halt_req_i,
    .sleep_req_i,
    .busreq_i,
    .bus_rel_en_i (cfg.bus_rel_en),
    .halt_deep_i  (cfg.halt_deep),
    .wake_i       (wake),
    .state_o      (state)
  );

  always_comb begin
    cpu_clk_en_o    = 1'b0;
    bus_clk_en_o    = 1'b0;
    dma_en_o        = 1'b0;
    periph_clk_en_o = 1'b0;
    unique case (state)
      ST_RUN: begin
        cpu_clk_en_o    = 1'b1;
        bus_clk_en_o    = 1'b1;
        dma_en_o        = 1'b1;
        periph_clk_en_o = 1'b1;
      end
      ST_HALT, ST_HALT_BUS: begin
        bus_clk_en_o    = 1'b1;
        periph_clk_en_o = 1'b1;
      end
      ST_HALT_DEEP: periph_clk_en_o = 1'b1;
      default: ;
    endcase
  end

  // settle state powers the fast oscillator even when slow clock is selected
  assign fast_osc_en_o = (state == ST_WAKE) || (state != ST_SLEEP && !cfg.slow_sel);
  assign refresh_en_o  = !cfg.slow_sel &&
                         (state == ST_RUN || state == ST_HALT || state == ST_HALT_BUS);
  assign slow_osc_en_o = cfg.slow_osc_on;
  assign sysclk_slow_o = cfg.slow_sel;
  assign mode_o        = state;

  stby_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni,
    .fast_run_i  (fast_osc_en_o),
    .div_sel_i   (cfg.div_sel),
    .slow_sel_i  (cfg.slow_sel),
    .slow_run_i  (cfg.slow_osc_on),
    .slow_tick_i,
    .tick_o      (sysclk_tick_o)
  );
endmodule

// File: rtl/stby_pwr_ctrl_chk.sv
module stby_pwr_ctrl_chk #(
  parameter int N_IRQ = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busreq_i,
  input logic [N_IRQ-1:0] irq_i,
  input logic             slow_tick_i,
  input logic             cpu_clk_en_o,
  input logic             bus_clk_en_o,
  input logic             dma_en_o,
  input logic             fast_osc_en_o,
  input logic             slow_osc_en_o,
  input logic             periph_clk_en_o,
  input logic             refresh_en_o,
  input logic             sysclk_slow_o,
  input logic             sysclk_tick_o,
  input logic [2:0]       mode_o
);
  p_cpu_off_standby_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd0) |-> !cpu_clk_en_o);

  p_dma_needs_cpu_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_clk_en_o |-> !dma_en_o);

  p_deep_bus_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |-> (!bus_clk_en_o && !refresh_en_o && periph_clk_en_o));

  p_sleep_all_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |-> (!fast_osc_en_o && !periph_clk_en_o && !bus_clk_en_o));

  p_bus_halt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && busreq_i) |=> (mode_o == 3'd2));

  p_bus_halt_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && !busreq_i) |=> (mode_o == 3'd0));

  p_halt_irq_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd1 || mode_o == 3'd3) && (|irq_i)) |=> (mode_o == 3'd0));

  p_sleep_exit_path_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |=> (mode_o == 3'd4 || mode_o == 3'd5));

  p_settle_osc_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5) |-> (fast_osc_en_o && !cpu_clk_en_o));

  p_slow_no_refresh_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysclk_slow_o |-> !refresh_en_o);

  p_slow_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysclk_slow_o |-> (sysclk_tick_o == (slow_tick_i && slow_osc_en_o)));
endmodule

bind stby_pwr_ctrl stby_pwr_ctrl_chk #(.N_IRQ(N_IRQ)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .busreq_i        (busreq_i),
  .irq_i           (irq_i),
  .slow_tick_i     (slow_tick_i),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .bus_clk_en_o    (bus_clk_en_o),
  .dma_en_o        (dma_en_o),
  .fast_osc_en_o   (fast_osc_en_o),
  .slow_osc_en_o   (slow_osc_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .refresh_en_o    (refresh_en_o),
  .sysclk_slow_o   (sysclk_slow_o),
  .sysclk_tick_o   (sysclk_tick_o),
  .mode_o          (mode_o)
);

// File: tb/test_stby_pwr_ctrl.sv
`timescale 1ns/1ps
module test_stby_pwr_ctrl;
  localparam int N_IRQ  = 2;
  localparam int N_PORT = 2;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, sleep_req = 0, busreq = 0, cfg_we = 0, slow_tick = 0;
  logic [N_IRQ-1:0]  irq = '0;
  logic [N_PORT-1:0] pin = '0, edge_cfg = '0;
  logic [5:0]        cfg_wdata = '0;
  logic [N_PORT-1:0] port_irq;
  logic cpu_en, bus_en, dma_en, fosc_en, sosc_en, per_en, ref_en, slow_sel, tick;
  logic [2:0] mode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  stby_pwr_ctrl #(.N_IRQ(N_IRQ), .N_PORT(N_PORT), .SETTLE_CYC(SETTLE)) i_stby_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .halt_req_i(halt_req), .sleep_req_i(sleep_req), .busreq_i(busreq),
    .irq_i(irq), .port_pin_i(pin), .port_edge_i(edge_cfg),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .slow_tick_i(slow_tick),
    .port_irq_o(port_irq), .cpu_clk_en_o(cpu_en), .bus_clk_en_o(bus_en),
    .dma_en_o(dma_en), .fast_osc_en_o(fosc_en), .slow_osc_en_o(sosc_en),
    .periph_clk_en_o(per_en), .refresh_en_o(ref_en), .sysclk_slow_o(slow_sel),
    .sysclk_tick_o(tick), .mode_o(mode)
  );

  function automatic logic [5:0] ens();
    return {cpu_en, bus_en, dma_en, per_en, fosc_en, ref_en};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // advance one edge, then settle for sampling
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [5:0] d);
    cfg_we = 1; cfg_wdata = d;
    step();
    cfg_we = 0;
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      if (tick) n++;
      step();
    end
  endtask

  // {we, wdata[5:0], halt, sleep, busreq, irq, expected enables {cpu,bus,dma,per,fosc,ref}}
  localparam logic [16:0] VEC [25] = '{
    {1'b1, 6'b000110, 4'b0000, 6'b111111},
    {1'b0, 6'b000000, 4'b1000, 6'b010111},
    {1'b0, 6'b000000, 4'b0000, 6'b010111},
    {1'b0, 6'b000000, 4'b0001, 6'b111111},
    {1'b0, 6'b000000, 4'b0010, 6'b010111},
    {1'b0, 6'b000000, 4'b0011, 6'b010111},
    {1'b0, 6'b000000, 4'b0001, 6'b111111},
    {1'b1, 6'b000111, 4'b0000, 6'b111111},
    {1'b0, 6'b000000, 4'b1000, 6'b000110},
    {1'b0, 6'b000000, 4'b0001, 6'b111111},
    {1'b0, 6'b000000, 4'b0100, 6'b000000},
    {1'b0, 6'b000000, 4'b0000, 6'b000000},
    {1'b0, 6'b000000, 4'b0001, 6'b000010},
    {1'b0, 6'b000000, 4'b0000, 6'b000010},
    {1'b0, 6'b000000, 4'b0000, 6'b000010},
    {1'b0, 6'b000000, 4'b0000, 6'b000010},
    {1'b0, 6'b000000, 4'b0000, 6'b111111},
    {1'b1, 6'b001111, 4'b0000, 6'b111100},
    {1'b1, 6'b000110, 4'b0000, 6'b111111},
    {1'b0, 6'b000000, 4'b1100, 6'b000000},
    {1'b0, 6'b000000, 4'b0001, 6'b000010},
    {1'b0, 6'b000000, 4'b0000, 6'b000010},
    {1'b0, 6'b000000, 4'b0000, 6'b000010},
    {1'b0, 6'b000000, 4'b0000, 6'b000010},
    {1'b0, 6'b000000, 4'b0000, 6'b111111}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    #12 rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 enables", ens(), 6'b111111);
    check("R1 mode", mode, 0);
    check("R1 slow osc", sosc_en, 1);
    check("R1 source", slow_sel, 0);
    check("R1 ratio1 tick", tick, 1);

    // R6 bus request ignored while release disabled
    busreq = 1; step(); busreq = 0;
    check("R6 busreq ignored", mode, 0);
    check("R6 busreq ignored en", ens(), 6'b111111);

    // vector walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 25; k++) begin
      cfg_we    = VEC[k][16];
      cfg_wdata = VEC[k][15:10];
      halt_req  = VEC[k][9];
      sleep_req = VEC[k][8];
      busreq    = VEC[k][7];
      irq       = {1'b0, VEC[k][6]};
      step();
      check($sformatf("R3-vector %0d (R4 R5 R6 R7 R8 R9)", k), ens(), VEC[k][5:0]);
    end
    cfg_we = 0; halt_req = 0; sleep_req = 0; busreq = 0; irq = '0;

    // R6 bus-halt mode code
    busreq = 1; step();
    check("R6 bus halt mode", mode, 2);
    busreq = 0; step();
    check("R6 bus halt exit", mode, 0);

    // R5 low-speed oscillator keeps running in sleep
    sleep_req = 1; step(); sleep_req = 0;
    check("R5 sleep mode", mode, 4);
    check("R5 slow osc in sleep", sosc_en, 1);
    irq = 2'b10; step(); irq = '0;
    check("R8 settle mode", mode, 5);
    repeat (SETTLE) step();
    check("R8 back to run", mode, 0);

    // R10 divider ratios
    write_cfg(6'b100110); repeat (10) step();
    count_ticks(16, n); check("R10 ratio4", n, 4);
    write_cfg(6'b110110); repeat (10) step();
    count_ticks(16, n); check("R10 ratio8", n, 2);
    write_cfg(6'b010110); repeat (10) step();
    count_ticks(16, n); check("R10 ratio2", n, 8);
    write_cfg(6'b000110); repeat (10) step();
    count_ticks(16, n); check("R10 ratio1", n, 16);

    // R11 slow source, R9 refresh/fast osc, R2 slow osc bit
    write_cfg(6'b001110);
    slow_tick = 1; #1;
    check("R11 slow tick high", tick, 1);
    check("R9 slow flag", slow_sel, 1);
    check("R9 refresh off", ref_en, 0);
    check("R9 fast osc off", fosc_en, 0);
    slow_tick = 0; #1;
    check("R11 slow tick low", tick, 0);
    write_cfg(6'b001010);
    slow_tick = 1; #1;
    check("R11 slow osc off tick", tick, 0);
    check("R2 slow osc bit", sosc_en, 0);
    slow_tick = 0;
    write_cfg(6'b000110);

    // R12 edge port in run: one-cycle pulse
    edge_cfg = 2'b01;
    pin = 2'b01; #1;
    check("R12 edge pulse", port_irq[0], 1);
    step();
    check("R12 edge single", port_irq[0], 0);
    pin = 2'b00; step();

    // R12 level in standby (bus halt keeps standby while pin high)
    busreq = 1; step();
    check("R6 bus halt entered", mode, 2);
    pin = 2'b01; step(); step();
    check("R12 level in standby", port_irq[0], 1);
    check("R6 irq does not clear bus halt", mode, 2);
    busreq = 0; step();
    check("R6 exit after busreq low", mode, 0);
    check("R12 edge again in run", port_irq[0], 0);
    pin = 2'b00; step();

    // R7 port interrupt wakes deep halt
    write_cfg(6'b000111);
    halt_req = 1; step(); halt_req = 0;
    check("R4 deep halt", mode, 3);
    pin = 2'b10; step();
    check("R7 port wake", mode, 0);
    check("R7 port wake en", ens(), 6'b111111);
    pin = 2'b00; step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule